// File: doc/BRIEF.md
# UART Modem-Line Flow Control Unit

This unit sits between a UART serializer/deserializer pair and the two modem-control pins. On the transmit side it grants permission to begin a new character only when the far end signals readiness on the active-low clear-to-send input (`ctsN`). It never interrupts a character the serializer has already started. A character that becomes ready while the far end is not ready waits, and it is released as soon as the line returns low. On the receive side it drives the active-low request-to-send level from the receive buffer's free-space flag.

The request-to-send pin can serve a second purpose. In driver-enable mode it carries the enable for an external line transceiver. That enable is active for as long as the serializer reports a character in flight, with no added guard time, and its polarity is selectable. The clear-to-send input passes through a synchronizer. Every change of the synchronized level sets a sticky change flag, and that flag can raise an interrupt.

The flow-control enables, the driver-enable mode and the polarity are captured only while the peripheral enable is low. They are frozen while it is high. The interrupt enable can be changed at any time.

Top module: `uart_flow_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `txStartOk` is 0, `rtsDePin` is 1 and `ctsIrq` is 0.
- R2: With clear-to-send gating off, `txStartOk` equals `periphEn & txPending & ~txBusy`, whatever the level of `ctsN`. It is always 0 while `periphEn` is 0.
- R3: With clear-to-send gating on, `txStartOk` additionally needs the synchronized `ctsN` to be low. A change on `ctsN` before clock edge k reaches `txStartOk` after edge k+1.
- R4: `txStartOk` is 0 while `txBusy` is 1, so a character in flight is never cut short. A pending character held back by a high `ctsN` is granted two edges after `ctsN` falls, with no re-request.
- R5: In request-to-send mode (peripheral enabled, RTS enable 1, driver-enable mode 0), `rtsDePin` equals the inverse of `rxSpace`, registered one clock later.
- R6: With driver-enable mode 0 and either RTS enable 0 or `periphEn` 0, `rtsDePin` is held at 1.
- R7: In driver-enable mode, `rtsDePin` one clock later equals `(periphEn & txBusy) XOR polarity`. A polarity of 0 means active high and a polarity of 1 means active low. This mode overrides the RTS enable.
- R8: Changes to `cfgCtsEn`, `cfgRtsEn`, `cfgDeMode` and `cfgDePol` while `periphEn` is 1 have no effect. Values present while `periphEn` is 0 are captured at each clock edge.
- R9: Any change of the synchronized `ctsN` level sets the change flag. A change before edge k shows on `ctsIrq` after edge k+2. `ctsIrq` equals the flag ANDed with `ctsIrqEn`, and the enable acts with no delay.
- R10: A 1 on `ctsFlagClr` clears the change flag at the next edge. A change detected in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periphEn | input | 1 | Peripheral enable; configuration frozen while 1 |
| cfgCtsEn | input | 1 | Clear-to-send gating enable |
| cfgRtsEn | input | 1 | Request-to-send output enable |
| cfgDeMode | input | 1 | Pin carries transceiver driver enable when 1 |
| cfgDePol | input | 1 | Driver-enable polarity: 0 active high, 1 active low |
| ctsIrqEn | input | 1 | Change-interrupt enable, writable at any time |
| txPending | input | 1 | A character is waiting to be sent |
| txBusy | input | 1 | Serializer is shifting a character (start bit to end of stop bit) |
| rxSpace | input | 1 | Receive buffer can accept another character |
| ctsN | input | 1 | Active-low clear-to-send pin, asynchronous |
| ctsFlagClr | input | 1 | Clears the change flag |
| txStartOk | output | 1 | Permission for the serializer to begin a character |
| rtsDePin | output | 1 | Request-to-send level or driver enable |
| ctsIrq | output | 1 | Clear-to-send change interrupt |

## Verification
A synchronizer stage that holds a stale value shows up as a `txStartOk` that reacts to `ctsN` one edge early or late. A stale previous-level register shows up as a missing or spurious `ctsIrq` three edges after a pin change. Corruption of the pin register or of the captured configuration appears on `rtsDePin` within one clock, as a wrong level for the mode in force. A configuration register that is not locked shows at once as a mode change while the peripheral is enabled. The sweeps therefore compare every output a fixed number of edges after each stimulus, never later.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

  typedef struct packed {
    logic ctsEn;
    logic rtsEn;
    logic deMode;
    logic dePol;
  } cfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic setFlag;
    logic clrFlag;
    logic pinNext;
  } strobe_t;

endpackage

// File: rtl/uart_fc_datapath.sv
module uart_fc_datapath
  import uart_fc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    ctsN,
  input  cfg_t    cfgIn,
  input  strobe_t strobes,
  output cfg_t    cfgQ,
  output logic    ctsLevel,
  output logic    ctsPrev,
  output logic    ctsFlag,
  output logic    pinQ
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[s] <= 1'b1;
          else       syncQ[s] <= ctsN;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[s] <= 1'b1;
          else       syncQ[s] <= syncQ[s-1];
      end
    end
  endgenerate

  assign ctsLevel = syncQ[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctsPrev <= 1'b1;
      ctsFlag <= 1'b0;
      cfgQ    <= '0;
      pinQ    <= 1'b1;
    end else begin
      ctsPrev <= ctsLevel;
      if (strobes.setFlag)      ctsFlag <= 1'b1;
      else if (strobes.clrFlag) ctsFlag <= 1'b0;
      if (strobes.loadCfg) cfgQ <= cfgIn;
      pinQ <= strobes.pinNext;
    end
  end

endmodule

// File: rtl/uart_fc_control.sv
module uart_fc_control
  import uart_fc_pkg::*;
(
  input  logic    periphEn,
  input  cfg_t    cfgQ,
  input  logic    ctsLevel,
  input  logic    ctsPrev,
  input  logic    ctsFlag,
  input  logic    ctsIrqEn,
  input  logic    ctsFlagClr,
  input  logic    txPending,
  input  logic    txBusy,
  input  logic    rxSpace,
  output strobe_t strobes,
  output logic    txStartOk,
  output logic    ctsIrq
);

  logic ctsReady;
  logic driveOn;

  // Far end ready when gating is off or synchronized line is low
  assign ctsReady  = !cfgQ.ctsEn || !ctsLevel;
  assign txStartOk = periphEn && txPending && !txBusy && ctsReady;
  assign driveOn   = periphEn && txBusy;
  assign ctsIrq    = ctsFlag && ctsIrqEn;

  always_comb begin
    strobes.loadCfg = !periphEn;
    strobes.setFlag = ctsLevel != ctsPrev;
    strobes.clrFlag = ctsFlagClr;
    if (cfgQ.deMode)
      strobes.pinNext = driveOn ^ cfgQ.dePol;
    else
      strobes.pinNext = !(periphEn && cfgQ.rtsEn && rxSpace);
  end

endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
  import uart_fc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic periphEn,
  input  logic cfgCtsEn,
  input  logic cfgRtsEn,
  input  logic cfgDeMode,
  input  logic cfgDePol,
  input  logic ctsIrqEn,
  input  logic txPending,
  input  logic txBusy,
  input  logic rxSpace,
  input  logic ctsN,
  input  logic ctsFlagClr,
  output logic txStartOk,
  output logic rtsDePin,
  output logic ctsIrq
);

  cfg_t    cfgIn;
  cfg_t    cfgQ;
  strobe_t strobes;
  logic    ctsLevel;
  logic    ctsPrev;
  logic    ctsFlag;

  assign cfgIn = '{ctsEn: cfgCtsEn, rtsEn: cfgRtsEn, deMode: cfgDeMode, dePol: cfgDePol};

  uart_fc_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctsN     (ctsN),
    .cfgIn    (cfgIn),
    .strobes  (strobes),
    .cfgQ     (cfgQ),
    .ctsLevel (ctsLevel),
    .ctsPrev  (ctsPrev),
    .ctsFlag  (ctsFlag),
    .pinQ     (rtsDePin)
  );

  uart_fc_control u_ctl (
    .periphEn   (periphEn),
    .cfgQ       (cfgQ),
    .ctsLevel   (ctsLevel),
    .ctsPrev    (ctsPrev),
    .ctsFlag    (ctsFlag),
    .ctsIrqEn   (ctsIrqEn),
    .ctsFlagClr (ctsFlagClr),
    .txPending  (txPending),
    .txBusy     (txBusy),
    .rxSpace    (rxSpace),
    .strobes    (strobes),
    .txStartOk  (txStartOk),
    .ctsIrq     (ctsIrq)
  );

endmodule

// File: rtl/uart_fc_checker.sv
module uart_fc_checker
  import uart_fc_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic periphEn,
  input logic ctsIrqEn,
  input logic txBusy,
  input logic rxSpace,
  input logic ctsN,
  input logic txStartOk,
  input logic rtsDePin,
  input logic ctsIrq,
  input cfg_t cfgQ
);

  p_no_start_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    !periphEn |-> !txStartOk);

  p_cts_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.ctsEn && ctsN && $past(ctsN) && $past(ctsN, 2)) |-> !txStartOk);

  p_busy_no_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    txBusy |-> !txStartOk);

  p_rts_follow_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(periphEn) && $past(cfgQ.rtsEn) && !$past(cfgQ.deMode))
      |-> (rtsDePin == !$past(rxSpace)));

  p_idle_pin_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cfgQ.deMode) && (!$past(periphEn) || !$past(cfgQ.rtsEn))) |-> rtsDePin);

  p_de_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(periphEn) && $past(cfgQ.deMode))
      |-> (rtsDePin == ($past(txBusy) ^ $past(cfgQ.dePol))));

  p_cfg_locked_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(periphEn) |-> $stable(cfgQ));

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctsIrq |-> ctsIrqEn);

endmodule

bind uart_flow_ctrl uart_fc_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .periphEn  (periphEn),
  .ctsIrqEn  (ctsIrqEn),
  .txBusy    (txBusy),
  .rxSpace   (rxSpace),
  .ctsN      (ctsN),
  .txStartOk (txStartOk),
  .rtsDePin  (rtsDePin),
  .ctsIrq    (ctsIrq),
  .cfgQ      (cfgQ)
);

// File: tb/tb_uart_flow_ctrl.sv
module tb_uart_flow_ctrl;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic periphEn = 1'b0;
  logic cfgCtsEn = 1'b0, cfgRtsEn = 1'b0, cfgDeMode = 1'b0, cfgDePol = 1'b0;
  logic ctsIrqEn = 1'b0;
  logic txPending = 1'b0, txBusy = 1'b0, rxSpace = 1'b0;
  logic ctsN = 1'b1;
  logic ctsFlagClr = 1'b0;
  logic txStartOk, rtsDePin, ctsIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_flow_ctrl dut (
    .clk(clk), .rstN(rstN), .periphEn(periphEn),
    .cfgCtsEn(cfgCtsEn), .cfgRtsEn(cfgRtsEn), .cfgDeMode(cfgDeMode), .cfgDePol(cfgDePol),
    .ctsIrqEn(ctsIrqEn), .txPending(txPending), .txBusy(txBusy), .rxSpace(rxSpace),
    .ctsN(ctsN), .ctsFlagClr(ctsFlagClr),
    .txStartOk(txStartOk), .rtsDePin(rtsDePin), .ctsIrq(ctsIrq)
  );

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // step n edges, sample 1 ns after the last
  task automatic edges(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic loadCfg(logic c, logic r, logic d, logic p);
    @(negedge clk);
    periphEn = 1'b0;
    cfgCtsEn = c; cfgRtsEn = r; cfgDeMode = d; cfgDePol = p;
    edges(2);
    @(negedge clk);
    periphEn = 1'b1;
  endtask

  task automatic clearFlag();
    @(negedge clk); ctsFlagClr = 1'b1;
    @(negedge clk); ctsFlagClr = 1'b0;
  endtask

  initial begin
    // R1: reset state
    edges(3);
    check("R1", "txStartOk in reset", txStartOk, 1'b0);
    check("R1", "pin in reset", rtsDePin, 1'b1);
    @(negedge clk); rstN = 1'b1;
    edges(1);
    check("R1", "txStartOk after reset", txStartOk, 1'b0);
    check("R1", "pin after reset", rtsDePin, 1'b1);
    check("R1", "irq after reset", ctsIrq, 1'b0);

    // R2 R3 R5 R6 R7: exhaustive sweep of configuration and static inputs
    for (int c = 0; c < 16; c++) begin
      loadCfg(c[3], c[2], c[1], c[0]);
      for (int v = 0; v < 16; v++) begin
        logic expOk, expPin;
        @(negedge clk);
        txPending = v[3]; txBusy = v[2]; rxSpace = v[1]; ctsN = v[0];
        edges(3);
        expOk = v[3] & ~v[2] & (~c[3] | ~v[0]);
        if (c[1]) expPin = v[2] ^ c[0];
        else      expPin = ~(c[2] & v[1]);
        check(c[3] ? "R3" : "R2", "sweep txStartOk", txStartOk, expOk);
        check(c[1] ? "R7" : (c[2] ? "R5" : "R6"), "sweep pin", rtsDePin, expPin);
      end
    end

    // R2 R6: disabled peripheral
    @(negedge clk);
    periphEn = 1'b0; cfgCtsEn = 1'b0; cfgRtsEn = 1'b1; cfgDeMode = 1'b0;
    txPending = 1'b1; txBusy = 1'b0; rxSpace = 1'b1; ctsN = 1'b0;
    edges(3);
    check("R2", "no start while disabled", txStartOk, 1'b0);
    check("R6", "pin idle while disabled", rtsDePin, 1'b1);

    // R3 R4: synchronizer latency and postponed start
    loadCfg(1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    txPending = 1'b1; txBusy = 1'b0; ctsN = 1'b1;
    edges(3);
    check("R4", "held while cts high", txStartOk, 1'b0);
    @(negedge clk); ctsN = 1'b0;
    edges(1);
    check("R3", "not yet after first edge", txStartOk, 1'b0);
    edges(1);
    check("R3", "granted after second edge", txStartOk, 1'b1);
    @(negedge clk); txBusy = 1'b1; ctsN = 1'b1;
    edges(3);
    check("R4", "blocked in flight", txStartOk, 1'b0);
    @(negedge clk); txBusy = 1'b0;
    edges(2);
    check("R4", "stopped after char with cts high", txStartOk, 1'b0);
    @(negedge clk); ctsN = 1'b0;
    edges(1);
    check("R4", "resume not before two edges", txStartOk, 1'b0);
    edges(1);
    check("R4", "resume two edges after cts low", txStartOk, 1'b1);

    // R9 R10: change flag and interrupt
    edges(3);
    clearFlag();
    edges(1);
    check("R10", "flag cleared", ctsIrq, 1'b0);
    @(negedge clk); ctsIrqEn = 1'b1;
    #1 check("R10", "irq low after clear", ctsIrq, 1'b0);
    @(negedge clk); ctsN = 1'b1;
    edges(1);
    check("R9", "irq not after edge k", ctsIrq, 1'b0);
    edges(1);
    check("R9", "irq not after edge k+1", ctsIrq, 1'b0);
    edges(1);
    check("R9", "irq after edge k+2", ctsIrq, 1'b1);
    @(negedge clk); ctsIrqEn = 1'b0;
    #1 check("R9", "enable masks at once", ctsIrq, 1'b0);
    @(negedge clk); ctsIrqEn = 1'b1;
    #1 check("R9", "flag sticky, unmask at once", ctsIrq, 1'b1);
    clearFlag();
    #1 check("R10", "clear drops irq", ctsIrq, 1'b0);
    @(negedge clk); ctsN = 1'b0;
    edges(3);
    check("R9", "falling change also flags", ctsIrq, 1'b1);
    clearFlag();
    ctsIrqEn = 1'b0;

    // R8: configuration frozen while enabled
    loadCfg(1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    cfgCtsEn = 1'b1; cfgRtsEn = 1'b1; cfgDeMode = 1'b1; cfgDePol = 1'b0;
    txPending = 1'b1; txBusy = 1'b0; rxSpace = 1'b1; ctsN = 1'b1;
    edges(3);
    check("R8", "cts gating change ignored", txStartOk, 1'b1);
    check("R8", "pin mode change ignored", rtsDePin, 1'b1);
    @(negedge clk); periphEn = 1'b0;
    @(negedge clk); periphEn = 1'b1;
    edges(3);
    check("R8", "captured while disabled", rtsDePin, 1'b0);
    check("R8", "cts gating now active", txStartOk, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule